// File: doc/BRIEF.md
# Ripple-Counter Bit Realignment Bank

A free-running counter whose carries travel one stage per clock through pipeline flops runs fast, but its bits are skewed in time. Bit k shows the count as it was k clocks earlier, so the parallel word is not a binary value. This block sits directly after such a counter. It gives every bit its own short delay so that all bits on the output describe the same moment, and the output word reads as plain binary.

Bit k needs a delay that, together with its own skew of k clocks, adds up to the skew of the top bit, N-1. Bit k repeats every 2^(k+1) clocks while the source counts steadily, so the required delay is reduced modulo that period. The delays are worked out from N when the design is elaborated. A bit that needs no delay passes straight through.

A run flag marks the clocks on which the source counter really advanced. The output is declared valid only after the flag has been high on N-1 edges in a row. That many edges fill every delay line with samples taken while the source counted steadily.

Top module: `realign_bank`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and every delay stage holds 0, so bin_o equals raw_i masked to the bits that have zero delay (0 when raw_i is 0).
- R2: Output bit k equals input bit k delayed by exactly (N-1-k) mod 2^(k+1) clocks, bit 0 being the least significant bit. For the default N=8 the delays for bits 0 to 7 are 1,2,5,4,3,2,1,0.
- R3: valid_o rises at the clock edge on which run_i has been sampled high for the (N-1)-th consecutive edge. It then stays high for as long as run_i stays high.
- R4: A clock edge that samples run_i low makes valid_o 0 after that edge.
- R5: Take c(t) as the number of edges since reset on which the source counter advanced. Whenever valid_o is 1 after edge t, bin_o equals c(t-N+1) mod 2^N.
- R6: The delay lines shift on every clock edge whatever the value of run_i, because carries inside the source keep moving during a pause.
- R7: After a pause of any length, R5 holds again as soon as valid_o rises, including when the count wraps past 2^N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared with the source counter |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | N | Skewed bits from the pipelined-carry counter |
| run_i | input | 1 | High on edges where the source counter advances |
| bin_o | output | N | Realigned binary count |
| valid_o | output | 1 | bin_o is a true binary value |

## Verification
The hardest situation to reach is a pause in the source counter. During a pause, carries still in flight keep changing the raw bits while the count stays the same. Afterwards the realignment must become exact again, and the output must also cross the wrap from all-ones to zero. The bench builds its own model of the pipelined-carry source and drives raw_i from it. The stimulus uses pauses of one, three and ten clocks, which is longer than the carry pipeline, and a long run that wraps the count. A separate phase holds run_i low and injects a one-clock pulse on every bit, which measures each delay line on its own.

// File: rtl/realign_pkg.sv
package realign_pkg;
  // lag for bit k: (n-1-k) mod 2^(k+1)
  function automatic int unsigned lag_of(input int unsigned n, input int unsigned k);
    int unsigned span;
    span = n - 1 - k;
    if (k + 1 >= 31) return span;
    return span % (32'd1 << (k + 1));
  endfunction
endpackage

// File: rtl/delay_line.sv
module delay_line #(
  parameter int unsigned LEN = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [LEN-1:0] sr_q;

  generate
    if (LEN == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[LEN-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[LEN-1];
endmodule

// File: rtl/fill_tracker.sv
module fill_tracker #(
  parameter int unsigned FILL = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic full_o
);
  localparam int unsigned W = (FILL < 2) ? 1 : $clog2(FILL + 1);
  localparam logic [W-1:0] FILL_W = W'(FILL);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q != FILL_W) cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = (cnt_q == FILL_W);
endmodule

// File: rtl/realign_bank.sv
module realign_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  input  logic         run_i,
  output logic [N-1:0] bin_o,
  output logic         valid_o
);
  localparam int unsigned FILL = N - 1;

  for (genvar k = 0; k < N; k++) begin : g_bit
    localparam int unsigned LAG = realign_pkg::lag_of(N, k);
    if (LAG == 0) begin : g_wire
      assign bin_o[k] = raw_i[k];
    end else begin : g_dly
      delay_line #(.LEN(LAG)) u_dl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw_i[k]),
        .q_o    (bin_o[k])
      );
    end
  end

  fill_tracker #(.FILL(FILL)) u_fill (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .full_o (valid_o)
  );
endmodule

// File: rtl/realign_bank_chk.sv
module realign_bank_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] raw_i,
  input logic         run_i,
  input logic [N-1:0] bin_o,
  input logic         valid_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 1'b1;
  end

  always_comb begin
    if (!rst_ni) AST_RESET_INVALID: assert (!valid_o); // R1
  end

  AST_STOP_DROPS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !valid_o); // R4

  AST_VALID_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && run_i) |=> valid_o); // R3

  AST_RISE_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(run_i)); // R3

  AST_COUNT_STEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |-> (bin_o == $past(bin_o) + {{(N-1){1'b0}}, 1'b1})); // R5

  for (genvar k = 0; k < N; k++) begin : g_lag
    localparam int unsigned LAG = realign_pkg::lag_of(N, k);
    if (LAG == 1) begin : g_l1
      AST_LAG_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd1) |-> (bin_o[k] == $past(raw_i[k]))); // R2
    end else if (LAG == 2) begin : g_l2
      AST_LAG_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd2) |-> (bin_o[k] == $past(raw_i[k], 2))); // R6
    end
  end
endmodule

bind realign_bank realign_bank_chk #(.N(N)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .raw_i   (raw_i),
  .run_i   (run_i),
  .bin_o   (bin_o),
  .valid_o (valid_o)
);

// File: tb/realign_bank_test.sv
module realign_bank_test;
  localparam int unsigned N = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] raw_i = '0;
  logic         run_i = 1'b0;
  logic [N-1:0] bin_o;
  logic         valid_o;

  realign_bank #(.N(N)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(raw_i), .run_i(run_i),
    .bin_o(bin_o), .valid_o(valid_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    logic         v;
    logic [N-1:0] val;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  // source model: pipelined-carry divide-by-two chain
  logic [N-1:0] m_q, m_p;
  int hist[$];
  int cnt_c;
  int run_len;

  function automatic int lag(int k);
    return (N - 1 - k) % (1 << (k + 1));
  endfunction

  task automatic check(bit ok, string tag, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor: pop and compare
  always @(negedge clk_i) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(valid_o == e.v, {e.tag, " valid"}, {{(N-1){1'b0}}, valid_o}, {{(N-1){1'b0}}, e.v});
      if (e.v) check(bin_o == e.val, {e.tag, " value R5"}, bin_o, e.val);
    end
  end

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    raw_i = '0;
    run_i = 1'b0;
    m_q = '0; m_p = '0;
    hist.delete();
    hist.push_back(0);
    cnt_c = 0;
    run_len = 0;
    #2;
    check(valid_o == 1'b0, "R1 valid in reset", {{(N-1){1'b0}}, valid_o}, '0);
    check(bin_o == '0, "R1 bin in reset", bin_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // one cycle: at negedge advance model with run_i used at the last edge
  task automatic step(bit next_run, string tag);
    logic [N-1:0] en, nq, np;
    exp_t e;
    int t;
    @(negedge clk_i);
    for (int k = 0; k < N; k++) begin
      en[k] = (k == 0) ? run_i : m_p[k-1];
      nq[k] = en[k] ? ~m_q[k] : m_q[k];
      np[k] = en[k] & m_q[k];
    end
    m_q = nq; m_p = np;
    if (run_i) begin cnt_c++; run_len++; end
    else run_len = 0;
    hist.push_back(cnt_c);
    raw_i = m_q;
    t = hist.size() - 1;
    e.v = (run_len >= N - 1);
    e.val = e.v ? N'(hist[t - (N - 1)]) : '0;
    e.tag = tag;
    exp_q.push_back(e);
    run_i = next_run;
  endtask

  task automatic run_for(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b1, tag);
  endtask

  task automatic pause_for(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    do_reset();

    // impulse phase: run_i low, one-clock pulse on every bit (R2, R6, R4)
    @(negedge clk_i);
    raw_i = '1;
    for (int j = 0; j < 2 * N; j++) begin
      logic [N-1:0] want;
      #2;
      for (int k = 0; k < N; k++) want[k] = (j == lag(k));
      check(bin_o == want, "R2 R6 impulse delay", bin_o, want);
      check(valid_o == 1'b0, "R4 valid with run low", {{(N-1){1'b0}}, valid_o}, '0);
      @(negedge clk_i);
      raw_i = '0;
    end

    // counting phase from a fresh reset
    do_reset();
    run_i = 1'b1;
    run_for(40, "R3 R5 first run");
    pause_for(3, "R4 short pause");
    run_for(20, "R7 resume");
    pause_for(10, "R4 R6 long pause");
    run_for(300, "R7 wrap");
    pause_for(1, "R4 single stop");
    run_for(12, "R7 after single stop");
    step(1'b0, "R5 tail");
    repeat (3) @(negedge clk_i);
    finish_up();
  end
endmodule